// File: doc/BRIEF.md
# SD Bus Clock Divider

This block derives the SD bus clock from a base clock. Software programs a 16-bit control word: one bit starts the internal clock, one bit lets the divided clock out to the card, and a divisor field picks the bus frequency. A read-only flag in the same word tells software when the internal clock has settled. The expected order of use is to clear the word, write the divisor together with the internal enable, poll the settled flag, and only then turn the output on.

Two divisor encodings exist, selected by the `HOST_VER` parameter. The older one holds an 8-bit power of two in bits 15:8. The newer one holds a 10-bit value split across the word, with its low byte in bits 15:8 and its top two bits in bits 7:6. In both encodings a nonzero value N gives a bus clock of the base clock divided by 2N, and zero passes the base clock straight through. Divisor updates made while the clock runs are held back until a low phase ends, so the card never sees a shortened pulse. A capabilities word reports the base clock frequency in MHz, where zero means the frequency is unknown.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word reads 0x0000 and `sd_clk` is low.
- R2: Bits 0 (internal enable) and 2 (output enable) and the divisor bits read back as written. Bits 5:3 always read zero, and writes to bit 1 have no effect.
- R3: Bit 1 (settled) reads 1 exactly `STABLE_CYC` base-clock edges after the write edge that sets bit 0. It reads 0 from the write edge that clears bit 0.
- R4: `sd_clk` stays low whenever bit 2 or bit 1 reads 0. Once either is clear, the divided output is low from the next base edge.
- R5: With `HOST_VER` of 2 or more, divisor N = {bits 7:6, bits 15:8}. A nonzero N gives a period of 2N base cycles, high for N cycles and low for N cycles.
- R6: With `HOST_VER` of 2 or more, N = 0 makes `sd_clk` follow the base clock (high in its high phase, low in its low phase).
- R7: With `HOST_VER` = 1, a single set bit at value f in bits 15:8 gives a period of 2f base cycles, and zero gives pass-through. Bits 7:6 are ignored and read zero.
- R8: With `HOST_VER` = 1, a field with several bits set is treated as its highest set bit alone.
- R9: A divisor written while the clock runs takes effect only at the end of a low phase. Every high and low phase therefore lasts the full old or the full new divisor, never a mix.
- R10: `caps_o` bits 15:8 carry `BASE_MHZ` and bits 7:0 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Control word read data, including the settled flag |
| caps_o | output | 16 | Capabilities word with the base frequency in MHz |
| sd_clk | output | 1 | Gated, divided SD bus clock |

## Verification
The assertions check on every cycle that the settled flag rises exactly `STABLE_CYC` edges after the internal enable and drops the moment the enable is cleared. They also check that the bus clock never rises unless both the settled flag and the output enable were set, and that the enable bits read back as written. Only the bench scenarios can show the actual division ratios and duty cycle for both encodings, the rounding of malformed older-style divisors, pass-through, and the phase lengths across a divisor change made while the clock runs.

// File: rtl/sdclk_pkg.sv
// sdclk_pkg: shared constants, types and helpers for the SD clock divider.
// Assumes a 16-bit control word and a 10-bit internal divisor.
package sdclk_pkg;

    localparam int CTL_W      = 16;
    localparam int DIV_W      = 10;
    localparam int LO_W       = 8;
    localparam int HI_W       = DIV_W - LO_W;

    localparam int BIT_INT_EN = 0;
    localparam int BIT_STABLE = 1;
    localparam int BIT_OUT_EN = 2;

    // Decoded settings handed from the register stage to the divider
    typedef struct packed {
        logic             int_en;
        logic             out_en;
        logic [DIV_W-1:0] half;
    } clk_cfg_t;

    // Keep only the highest set bit of an older-style divisor field
    function automatic logic [LO_W-1:0] keep_top_bit(input logic [LO_W-1:0] f);
        logic [LO_W-1:0] r;
        r = '0;
        for (int i = 0; i < LO_W; i++) begin
            if (f[i]) r = LO_W'(1) << i;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdclk_regs.sv
// sdclk_regs: holds the control word and decodes the divisor.
// HOST_VER < 2 selects the power-of-two encoding, otherwise the split
// 10-bit encoding. The settled flag arrives from sdclk_stable and is
// masked by the internal enable so it drops on the clearing write edge.
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int HOST_VER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LO_W-1:0]  wr_lo,
    input  logic [HI_W-1:0]  wr_hi,
    input  logic             wr_int_en,
    input  logic             wr_out_en,
    input  logic             stable_raw,
    output logic             stable,
    output clk_cfg_t         cfg,
    output logic [CTL_W-1:0] rdata
);

    logic            int_en_q;
    logic            out_en_q;
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_rd;

    // Capture the enables and the low divisor byte on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en_q <= 1'b0;
            out_en_q <= 1'b0;
            lo_q     <= '0;
        end else if (wr) begin
            int_en_q <= wr_int_en;
            out_en_q <= wr_out_en;
            lo_q     <= wr_lo;
        end
    end

    generate
        if (HOST_VER < 2) begin : g_pow2
            logic unused_hi_bits;
            assign unused_hi_bits = ^wr_hi;
            assign hi_rd          = '0;
            // Divisor is the top set bit of the byte field
            assign cfg.half       = {{HI_W{1'b0}}, keep_top_bit(lo_q)};
        end else begin : g_split
            logic [HI_W-1:0] hi_q;
            // Capture the upper divisor bits on a write
            always_ff @(posedge clk) begin
                if (!rst_n)  hi_q <= '0;
                else if (wr) hi_q <= wr_hi;
            end
            assign hi_rd    = hi_q;
            assign cfg.half = {hi_q, lo_q};
        end
    endgenerate

    assign stable     = stable_raw & int_en_q;
    assign cfg.int_en = int_en_q;
    assign cfg.out_en = out_en_q;

    // Assemble the readable control word
    always_comb begin
        rdata             = '0;
        rdata[15:8]       = lo_q;
        rdata[7:6]        = hi_rd;
        rdata[BIT_OUT_EN] = out_en_q;
        rdata[BIT_STABLE] = stable;
        rdata[BIT_INT_EN] = int_en_q;
    end

endmodule

// File: rtl/sdclk_stable.sv
// sdclk_stable: models internal clock settling. The flag rises
// STABLE_CYC edges after the internal enable is seen and clears while
// the enable is low. Assumes STABLE_CYC >= 1.
module sdclk_stable #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_en,
    output logic stable_raw
);

    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          st_q;

    // Count settling cycles while enabled, restart when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !int_en) begin
            cnt_q <= '0;
            st_q  <= 1'b0;
        end else if (!st_q) begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= (cnt_q + 1'b1) == CW'(STABLE_CYC);
        end
    end

    assign stable_raw = st_q;

endmodule

// File: rtl/sdclk_div.sv
// sdclk_div: divides the base clock by 2*half, or passes it through when
// half is zero. A new half value is loaded only while stopped, in
// pass-through, or at the end of a low phase, so no phase is cut short.
// The pass-through gate is retimed on the falling edge so it switches
// only while the base clock is low.
module sdclk_div
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_new,
    output logic             sd_clk
);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic             div_q;
    logic             gate_q;
    logic             bypass;
    logic             phase_end;

    assign bypass    = (half_q == '0);
    assign phase_end = (cnt_q == half_q - DIV_W'(1));

    // Advance the phase counter and toggle the divided output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (!run || bypass) begin
            half_q <= half_new;
            cnt_q  <= '0;
            div_q  <= 1'b0;
        end else if (phase_end) begin
            cnt_q <= '0;
            if (div_q) begin
                div_q <= 1'b0;
            end else begin
                half_q <= half_new;
                div_q  <= (half_new != '0);
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Open the pass-through gate only while the base clock is low
    always_ff @(negedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= run & bypass;
    end

    assign sd_clk = div_q | (clk & gate_q);

endmodule

// File: rtl/sdclk_gen.sv
// sdclk_gen: top of the SD bus clock divider. Joins the control word,
// the settling model and the divider, and reports the base frequency.
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int         HOST_VER   = 2,
    parameter logic [7:0] BASE_MHZ   = 8'd50,
    parameter int         STABLE_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [15:0] ctrl_wdata,
    output logic [15:0] ctrl_rdata,
    output logic [15:0] caps_o,
    output logic        sd_clk
);

    clk_cfg_t cfg;
    logic     stable_raw;
    logic     stable;
    logic     run;
    logic     unused_ctl_bits;

    assign unused_ctl_bits = ^{ctrl_wdata[5:3], ctrl_wdata[BIT_STABLE]};

    sdclk_regs #(.HOST_VER(HOST_VER)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctrl_wr),
        .wr_lo      (ctrl_wdata[15:8]),
        .wr_hi      (ctrl_wdata[7:6]),
        .wr_int_en  (ctrl_wdata[BIT_INT_EN]),
        .wr_out_en  (ctrl_wdata[BIT_OUT_EN]),
        .stable_raw (stable_raw),
        .stable     (stable),
        .cfg        (cfg),
        .rdata      (ctrl_rdata)
    );

    sdclk_stable #(.STABLE_CYC(STABLE_CYC)) u_stable (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_en     (cfg.int_en),
        .stable_raw (stable_raw)
    );

    assign run = cfg.out_en & stable;

    sdclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_new (cfg.half),
        .sd_clk   (sd_clk)
    );

    assign caps_o = {BASE_MHZ, 8'h00};

endmodule

// File: rtl/sdclk_gen_chk.sv
// sdclk_gen_chk: port-level properties of sdclk_gen, bound to every
// instance. Counts the cycles the internal enable has been set to
// check the settling delay without a long $past window.
module sdclk_gen_chk #(
    parameter int STABLE_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        wr_int_en,
    input logic        wr_out_en,
    input logic [15:0] ctrl_rdata,
    input logic        sd_clk
);

    logic [15:0] en_cnt;

    // Count sampled cycles with the internal enable reading 1, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_rdata[0]) en_cnt <= '0;
        else if (en_cnt != 16'hFFFF)  en_cnt <= en_cnt + 1'b1;
    end

    p_stable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !wr_int_en |=> !ctrl_rdata[1]);

    p_stable_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rdata[1]) |-> (en_cnt == 16'(STABLE_CYC)));

    p_stable_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[1] |-> ctrl_rdata[0]);

    p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata[1] || !ctrl_rdata[2]) |=> !sd_clk);

    p_rise_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_clk) |-> $past(ctrl_rdata[1] && ctrl_rdata[2]));

    p_enable_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl_rdata[0] == $past(wr_int_en))
                 && (ctrl_rdata[2] == $past(wr_out_en)));

endmodule

bind sdclk_gen sdclk_gen_chk #(.STABLE_CYC(STABLE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .wr_int_en  (ctrl_wdata[0]),
    .wr_out_en  (ctrl_wdata[2]),
    .ctrl_rdata (ctrl_rdata),
    .sd_clk     (sd_clk)
);

// File: tb/sim_sdclk_gen.sv
// sim_sdclk_gen: scoreboard bench. u0 uses the split encoding, u1 the
// power-of-two encoding. Tasks push expected items, measurements push
// actual values, and a monitor pops and compares them.
module sim_sdclk_gen;

    localparam int SCYC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic [15:0] wd_a = '0, wd_b = '0;
    logic [15:0] rd_a, rd_b, caps_a, caps_b;
    logic        sd_a, sd_b;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    act_q[$];
    item_t cur_e;
    int    cur_a;

    always #4 clk = ~clk;

    sdclk_gen #(.HOST_VER(2), .BASE_MHZ(8'd50), .STABLE_CYC(SCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_a), .ctrl_wdata(wd_a),
        .ctrl_rdata(rd_a), .caps_o(caps_a), .sd_clk(sd_a));

    sdclk_gen #(.HOST_VER(1), .BASE_MHZ(8'd200), .STABLE_CYC(SCYC)) u1 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_b), .ctrl_wdata(wd_b),
        .ctrl_rdata(rd_b), .caps_o(caps_b), .sd_clk(sd_b));

    // Monitor: pop expected and actual items and compare them
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_a = act_q.pop_front();
            checks++;
            if (cur_a != cur_e.val) begin
                fails++;
                $display("FAIL %s actual=%0d expected=%0d", cur_e.tag, cur_a, cur_e.val);
            end
        end
    end

    task automatic expect_item(input string tag, input int e);
        item_t it;
        it.tag = tag;
        it.val = e;
        exp_q.push_back(it);
    endtask

    task automatic report(input int a);
        act_q.push_back(a);
    endtask

    function automatic logic sdc(input bit w);
        return w ? sd_b : sd_a;
    endfunction

    function automatic logic [15:0] rdw(input bit w);
        return w ? rd_b : rd_a;
    endfunction

    task automatic wr(input bit w, input logic [15:0] d);
        @(negedge clk);
        if (w) begin wr_b = 1'b1; wd_b = d; end
        else   begin wr_a = 1'b1; wd_a = d; end
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    // Period and high time in base cycles, measured from a rising edge
    task automatic meas(input bit w, output int per, output int hi);
        logic p;
        logic c;
        int   guard;
        guard = 0;
        p = sdc(w);
        forever begin
            @(negedge clk);
            c = sdc(w);
            guard++;
            if ((!p && c) || guard > 5000) break;
            p = c;
        end
        hi = 1; per = 0; p = 1'b1;
        forever begin
            @(negedge clk);
            per++;
            c = sdc(w);
            if ((!p && c) || per > 5000) break;
            if (c) hi++;
            p = c;
        end
    endtask

    // Matches of sd_clk to the base clock level over n cycles
    task automatic follow(input bit w, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            if (sdc(w) == 1'b1) hits++;
            @(negedge clk); #2;
            if (sdc(w) == 1'b0) hits++;
        end
    endtask

    // Samples of sd_clk high in both phases over n cycles
    task automatic highs(input bit w, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            if (sdc(w)) cnt++;
            @(negedge clk); #2;
            if (sdc(w)) cnt++;
        end
    endtask

    task automatic check_period(input bit w, input string tag, input int e);
        int per, hi;
        meas(w, per, hi);
        expect_item({tag, " period"}, e);
        report(per);
        expect_item({tag, " high time"}, e / 2);
        report(hi);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, hits, lenrun, bad, seen_new;
        logic p, c;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_item("R1 u0 control after reset", 0); report(rd_a);
        expect_item("R1 u1 control after reset", 0); report(rd_b);
        expect_item("R1 sd_clk low after reset", 0); report(sd_a);

        // R10: capabilities report the base frequency
        expect_item("R10 u0 caps", 16'h3200); report(caps_a);
        expect_item("R10 u1 caps", 16'hC800); report(caps_b);

        // R3/R4: enables written before the clock has settled
        wr(0, 16'h0000);
        wr(0, 16'h0305);
        expect_item("R3 settled low on enable", 0); report(rd_a[1]);
        highs(0, SCYC - 2, n);
        expect_item("R4 no clock before settled", 0); report(n);
        @(negedge clk);
        expect_item("R3 settled still low one edge early", 0); report(rd_a[1]);
        @(negedge clk);
        expect_item("R3 settled after STABLE_CYC edges", 1); report(rd_a[1]);

        // R5: split divisor 3 gives period 6
        check_period(0, "R5 N=3", 6);
        expect_item("R2 readback", 16'h0307); report(rd_a);

        // R9: change divisor while running, phases must be 3 or 5 only
        wr(0, 16'h0505);
        p = sd_a; lenrun = 0; bad = 0; seen_new = 0; n = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            c = sd_a;
            lenrun++;
            if (c != p) begin
                if (n > 0) begin
                    if (lenrun == 5) seen_new = 1;
                    else if (lenrun != 3 || seen_new == 1) bad++;
                end
                n++;
                lenrun = 0;
            end
            p = c;
        end
        expect_item("R9 no short or mixed phases", 0); report(bad);
        expect_item("R9 new divisor reached", 1); report(seen_new);
        check_period(0, "R9 N=5", 10);

        // R5: upper divisor bits in 7:6 give N=0x105
        wr(0, 16'h0545);
        check_period(0, "R5 N=261", 522);
        expect_item("R2 readback split", 16'h0547); report(rd_a);

        // R6: zero divisor passes the base clock
        wr(0, 16'h0005);
        repeat (600) @(negedge clk);
        follow(0, 8, hits);
        expect_item("R6 pass-through", 16); report(hits);

        wr(0, 16'h0105);
        repeat (4) @(negedge clk);
        check_period(0, "R5 N=1", 2);

        // R4: output enable cleared keeps the clock low
        wr(0, 16'h0101);
        highs(0, 20, n);
        expect_item("R4 off with output disabled", 0); report(n);
        expect_item("R2 readback output off", 16'h0103); report(rd_a);

        // R3: settled drops on the clearing write
        wr(0, 16'h0000);
        expect_item("R3 settled clears at once", 0); report(rd_a[1]);

        // R2: bit 1 and bits 5:3 cannot be written
        wr(0, 16'h003A);
        expect_item("R2 reserved and settled ignore writes", 0); report(rd_a);
        highs(0, 10, n);
        expect_item("R4 idle after ignored write", 0); report(n);

        // R7/R8: power-of-two encoding on u1
        wr(1, 16'h0000);
        wr(1, 16'h0105);
        repeat (SCYC + 2) @(negedge clk);
        check_period(1, "R7 f=1", 2);
        wr(1, 16'h0405);
        check_period(1, "R7 f=4", 8);
        wr(1, 16'h06C5);
        check_period(1, "R8 f=6 rounds to 4", 8);
        expect_item("R7 bits 7:6 read zero", 16'h0607); report(rd_b);
        wr(1, 16'hFF05);
        check_period(1, "R8 f=0xFF rounds to 0x80", 256);
        wr(1, 16'h0005);
        repeat (300) @(negedge clk);
        follow(1, 8, hits);
        expect_item("R7 zero field passes through", 16); report(hits);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule